// File: doc/BRIEF.md
# Private interrupt priority selector

This block looks at a processor's private interrupt lines, normally 32 of them, and each cycle picks the one that should be shown to the processor interface. For every line it takes pending, enable and active bits, an 8-bit priority and a 2-bit group code. It also takes one enable bit per group. The winner's ID, priority and group, plus a valid flag, are registered and appear one clock after the inputs that produced them. When no line qualifies, the block shows the idle priority 0xFF.

The block also tracks whether its processor is asleep. A write to the wake port loads the sleep state, and the state can be read back as two status bits. From the sleep state, the group enables and one disable bit per group, it computes whether this processor may be chosen as the target of a distributed (one-of-many) interrupt. A status lookup port returns the two-bit state of any single line.

Top module: `hpsel_top`

## Requirements
- R1: A line is a candidate only when its pending bit is 1, its enable bit is 1, its active bit is 0, its group code is not 3 (reserved), and the group enable bit indexed by that code is 1. The group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1.
- R2: Among the candidates, the one with the numerically lowest priority value is selected.
- R3: When several candidates share the lowest priority value, the one with the lowest ID is selected.
- R4: With no candidate, `hp_valid_o` is 0, `hp_prio_o` is 0xFF, and `hp_id_o` and `hp_grp_o` are 0.
- R5: The selection outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R6: `stat_o` gives the state of the line chosen by `stat_sel_i` without delay: 00 inactive, 01 pending only, 10 active only, 11 active and pending. Bit 0 is the pending bit and bit 1 is the active bit.
- R7: The sleep state is 1 after reset. A clock edge with `wake_wr_i` high loads it from `wake_sleep_i`. `wake_bits_o` shows the sleep state in both bits (bit 1 children asleep, bit 0 processor asleep).
- R8: `tgt_ok_o[g]` is 1 only when the processor is awake, group g is enabled and group g's disable bit `grp_dis_i[g]` is 0. It reacts without delay to the enable and disable inputs.
- R9: During reset, the outputs are: valid 0, priority 0xFF, ID 0, group 0, and wake bits 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pend_i | input | N_IRQ | Pending bit per line |
| irq_en_i | input | N_IRQ | Enable bit per line |
| irq_act_i | input | N_IRQ | Active bit per line |
| irq_prio_i | input | N_IRQ*PRIO_W | Priority per line; line i is in bits [i*PRIO_W +: PRIO_W] |
| irq_grp_i | input | 2*N_IRQ | Group code per line; line i is in bits [2*i +: 2] |
| grp_en_i | input | 3 | Enable per group code |
| grp_dis_i | input | 3 | Target-selection disable per group code |
| wake_wr_i | input | 1 | Loads the sleep state |
| wake_sleep_i | input | 1 | Sleep value to load |
| wake_bits_o | output | 2 | {children asleep, processor asleep} |
| stat_sel_i | input | ID_W | Line to report on `stat_o` |
| stat_o | output | 2 | {active, pending} of the chosen line |
| hp_valid_o | output | 1 | A candidate was selected |
| hp_id_o | output | ID_W | Selected line ID |
| hp_prio_o | output | PRIO_W | Selected priority, 0xFF when idle |
| hp_grp_o | output | 2 | Selected group code |
| tgt_ok_o | output | 3 | Processor may be chosen for a distributed interrupt of that group |

## Verification
The assertions are checked on every cycle and cover four properties:
- an idle result always carries priority 0xFF;
- a valid result always names a line that was pending, enabled and inactive one cycle earlier;
- a sleeping processor is never offered as a target;
- a wake write is reflected in the sleep bit at the next edge.

Only the bench scenarios can show which candidate wins. That covers the lowest-value rule, the tie-break toward the lowest ID, masking by a disabled or reserved group, and the one-cycle latency. The bench drives directed priority ties and random traffic and compares the outputs against its reference model on every clock.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;
    localparam int GRP_N = 3;

    typedef enum logic [1:0] {
        GRP_ZERO = 2'd0,
        GRP_ONE_S = 2'd1,
        GRP_ONE_NS = 2'd2,
        GRP_RSVD = 2'd3
    } grp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PEND = 2'b01,
        ST_ACT = 2'b10,
        ST_BOTH = 2'b11
    } irq_state_e;
endpackage

// File: rtl/hpsel_cand.sv
module hpsel_cand #(
    parameter int N_IRQ = 32
) (
    input  logic [N_IRQ-1:0]             pend,
    input  logic [N_IRQ-1:0]             en,
    input  logic [N_IRQ-1:0]             act,
    input  logic [2*N_IRQ-1:0]           grp,
    input  logic [hpsel_pkg::GRP_N-1:0]  grp_en,
    output logic [N_IRQ-1:0]             cand
);
    logic [3:0] grp_en_pad;
    assign grp_en_pad = {1'b0, grp_en};

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        logic [1:0] code;
        assign code = grp[2*g +: 2];
        assign cand[g] = pend[g] & en[g] & ~act[g] & grp_en_pad[code];
    end
endmodule

// File: rtl/hpsel_pick.sv
module hpsel_pick #(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 8,
    localparam int ID_W  = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0]        cand,
    input  logic [N_IRQ*PRIO_W-1:0] prio,
    input  logic [2*N_IRQ-1:0]      grp,
    output logic                    vld,
    output logic [ID_W-1:0]         id,
    output logic [PRIO_W-1:0]       pr,
    output logic [1:0]              gr
);
    always_comb begin
        vld = 1'b0;
        id  = '0;
        pr  = '1;
        gr  = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand[i] && (!vld || prio[i*PRIO_W +: PRIO_W] < pr)) begin
                vld = 1'b1;
                id  = ID_W'(i);
                pr  = prio[i*PRIO_W +: PRIO_W];
                gr  = grp[2*i +: 2];
            end
        end
    end
endmodule

// File: rtl/hpsel_target.sv
module hpsel_target #(
    parameter int N_IRQ = 32,
    localparam int ID_W = $clog2(N_IRQ)
) (
    input  logic                         asleep,
    input  logic [hpsel_pkg::GRP_N-1:0]  grp_en,
    input  logic [hpsel_pkg::GRP_N-1:0]  grp_dis,
    input  logic [N_IRQ-1:0]             pend,
    input  logic [N_IRQ-1:0]             act,
    input  logic [ID_W-1:0]              sel,
    output logic [hpsel_pkg::GRP_N-1:0]  tgt_ok,
    output logic [1:0]                   stat
);
    assign tgt_ok = {hpsel_pkg::GRP_N{~asleep}} & grp_en & ~grp_dis;
    assign stat   = {act[sel], pend[sel]};
endmodule

// File: rtl/hpsel_top.sv
module hpsel_top #(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 8,
    localparam int ID_W  = $clog2(N_IRQ)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_IRQ-1:0]             irq_pend_i,
    input  logic [N_IRQ-1:0]             irq_en_i,
    input  logic [N_IRQ-1:0]             irq_act_i,
    input  logic [N_IRQ*PRIO_W-1:0]      irq_prio_i,
    input  logic [2*N_IRQ-1:0]           irq_grp_i,
    input  logic [hpsel_pkg::GRP_N-1:0]  grp_en_i,
    input  logic [hpsel_pkg::GRP_N-1:0]  grp_dis_i,
    input  logic                         wake_wr_i,
    input  logic                         wake_sleep_i,
    output logic [1:0]                   wake_bits_o,
    input  logic [ID_W-1:0]              stat_sel_i,
    output logic [1:0]                   stat_o,
    output logic                         hp_valid_o,
    output logic [ID_W-1:0]              hp_id_o,
    output logic [PRIO_W-1:0]            hp_prio_o,
    output logic [1:0]                   hp_grp_o,
    output logic [hpsel_pkg::GRP_N-1:0]  tgt_ok_o
);
    typedef struct packed {
        logic              asleep;
        logic              vld;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic [1:0]        grp;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [N_IRQ-1:0]  cand;
    logic              pk_vld;
    logic [ID_W-1:0]   pk_id;
    logic [PRIO_W-1:0] pk_prio;
    logic [1:0]        pk_grp;

    hpsel_cand #(.N_IRQ(N_IRQ)) u_cand (
        .pend(irq_pend_i), .en(irq_en_i), .act(irq_act_i),
        .grp(irq_grp_i), .grp_en(grp_en_i), .cand(cand)
    );

    hpsel_pick #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_pick (
        .cand(cand), .prio(irq_prio_i), .grp(irq_grp_i),
        .vld(pk_vld), .id(pk_id), .pr(pk_prio), .gr(pk_grp)
    );

    hpsel_target #(.N_IRQ(N_IRQ)) u_tgt (
        .asleep(st_q.asleep), .grp_en(grp_en_i), .grp_dis(grp_dis_i),
        .pend(irq_pend_i), .act(irq_act_i), .sel(stat_sel_i),
        .tgt_ok(tgt_ok_o), .stat(stat_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = pk_vld;
        st_d.id   = pk_id;
        st_d.prio = pk_prio;
        st_d.grp  = pk_grp;
        if (wake_wr_i) begin
            st_d.asleep = wake_sleep_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.asleep <= 1'b1;
            st_q.vld    <= 1'b0;
            st_q.id     <= '0;
            st_q.prio   <= '1;
            st_q.grp    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hp_valid_o  = st_q.vld;
    assign hp_id_o     = st_q.id;
    assign hp_prio_o   = st_q.prio;
    assign hp_grp_o    = st_q.grp;
    assign wake_bits_o = {st_q.asleep, st_q.asleep};
endmodule

// File: rtl/hpsel_chk.sv
module hpsel_chk #(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 8,
    localparam int ID_W  = $clog2(N_IRQ)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_IRQ-1:0]             irq_pend_i,
    input logic [N_IRQ-1:0]             irq_en_i,
    input logic [N_IRQ-1:0]             irq_act_i,
    input logic                         wake_wr_i,
    input logic                         wake_sleep_i,
    input logic [1:0]                   wake_bits_o,
    input logic                         hp_valid_o,
    input logic [ID_W-1:0]              hp_id_o,
    input logic [PRIO_W-1:0]            hp_prio_o,
    input logic [hpsel_pkg::GRP_N-1:0]  tgt_ok_o
);
    logic             armed_q;
    logic [N_IRQ-1:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            live_q  <= '0;
        end else begin
            armed_q <= 1'b1;
            live_q  <= irq_pend_i & irq_en_i & ~irq_act_i;
        end
    end

    assert_idle_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_valid_o |-> hp_prio_o == {PRIO_W{1'b1}});

    assert_winner_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && hp_valid_o) |-> live_q[hp_id_o]);

    assert_sleep_no_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_bits_o[0] |-> tgt_ok_o == '0);

    assert_wake_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wake_wr_i)) |-> wake_bits_o[0] == $past(wake_sleep_i));
endmodule

bind hpsel_top hpsel_chk #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_hpsel_chk (
    .clk(clk), .rst_n(rst_n), .irq_pend_i(irq_pend_i), .irq_en_i(irq_en_i),
    .irq_act_i(irq_act_i), .wake_wr_i(wake_wr_i), .wake_sleep_i(wake_sleep_i),
    .wake_bits_o(wake_bits_o), .hp_valid_o(hp_valid_o), .hp_id_o(hp_id_o),
    .hp_prio_o(hp_prio_o), .tgt_ok_o(tgt_ok_o)
);

// File: tb/test_hpsel_top.sv
`timescale 1ns/1ps
module test_hpsel_top;
    localparam int N  = 32;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0, en = '0, act = '0;
    logic [N*PW-1:0] prio = '0;
    logic [2*N-1:0]  grp = '0;
    logic [2:0]    gen = '0, gdis = '0;
    logic          wwr = 1'b0, wsl = 1'b0;
    logic [4:0]    ssel = '0;
    logic [1:0]    wbits, stat, hgrp;
    logic          hvld;
    logic [4:0]    hid;
    logic [7:0]    hprio;
    logic [2:0]    tgt;

    int total = 0;
    int bad = 0;
    int m_sleep = 1;
    int e_vld, e_id, e_prio, e_grp;

    always #4 clk = ~clk;

    hpsel_top i_hpsel_top (
        .clk(clk), .rst_n(rst_n), .irq_pend_i(pend), .irq_en_i(en),
        .irq_act_i(act), .irq_prio_i(prio), .irq_grp_i(grp),
        .grp_en_i(gen), .grp_dis_i(gdis), .wake_wr_i(wwr),
        .wake_sleep_i(wsl), .wake_bits_o(wbits), .stat_sel_i(ssel),
        .stat_o(stat), .hp_valid_o(hvld), .hp_id_o(hid),
        .hp_prio_o(hprio), .hp_grp_o(hgrp), .tgt_ok_o(tgt)
    );

    task automatic chk(input string req, input int act_v, input int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // reference model: scan all lines, keep strictly better priority
    task automatic model();
        e_vld = 0; e_id = 0; e_prio = 255; e_grp = 0;
        for (int i = 0; i < N; i++) begin
            int g = grp[2*i +: 2];
            int p = prio[i*PW +: PW];
            bit ok = pend[i] && en[i] && !act[i] && g != 3 && gen[g];
            if (ok && (e_vld == 0 || p < e_prio)) begin
                e_vld = 1; e_id = i; e_prio = p; e_grp = g;
            end
        end
    endtask

    task automatic comb_checks();
        #1;
        for (int g = 0; g < 3; g++)
            chk("R8 target", tgt[g], (m_sleep == 0 && gen[g] && !gdis[g]) ? 1 : 0);
        chk("R6 status", stat, {act[ssel], pend[ssel]});
    endtask

    task automatic tick(input string req);
        model();
        comb_checks();
        @(posedge clk);
        if (wwr) m_sleep = wsl;
        @(negedge clk);
        chk({req, " valid"}, hvld, e_vld);
        chk({req, " id"}, hid, e_id);
        chk({req, " prio"}, hprio, e_prio);
        chk({req, " grp"}, hgrp, e_grp);
        chk("R7 wake bits", wbits, {m_sleep[0], m_sleep[0]});
    endtask

    task automatic set_line(input int i, input int p, input int g);
        pend[i] = 1'b1; en[i] = 1'b1; act[i] = 1'b0;
        prio[i*PW +: PW] = PW'(p);
        grp[2*i +: 2] = 2'(g);
    endtask

    task automatic clear_all();
        pend = '0; en = '0; act = '0; prio = '0; grp = '0;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset values
        chk("R9 valid", hvld, 0);
        chk("R9 prio", hprio, 8'hFF);
        chk("R9 id", hid, 0);
        chk("R9 wake", wbits, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        gen = 3'b111;
        tick("R4 idle");

        // R1 single candidate
        set_line(7, 8'h40, 2);
        tick("R1 single");

        // R3 tie between id 3 and id 20
        clear_all();
        set_line(20, 8'h10, 1);
        set_line(3, 8'h10, 0);
        tick("R3 tie");

        // R2 lower value at higher id wins; R5 no change before the edge
        set_line(30, 8'h05, 2);
        #1 chk("R5 hold id", hid, 3);
        tick("R2 lower value");

        // R1 masking: active, disabled, group off, reserved code
        act[30] = 1'b1;
        en[3] = 1'b0;
        gen = 3'b110;
        grp[2*20 +: 2] = 2'd3;
        tick("R1 masked");
        chk("R4 idle id", hid, 0);

        // R1 group gating: re-enable group 0 with a line in it
        gen = 3'b111;
        en[3] = 1'b1;
        tick("R1 group on");

        // R6 status codes
        clear_all();
        ssel = 5'd9;
        for (int k = 0; k < 4; k++) begin
            pend[9] = k[0]; act[9] = k[1];
            tick("R6 status scan");
        end

        // R7 wake and R8 targeting
        wwr = 1'b1; wsl = 1'b0;
        tick("R7 wake write");
        wwr = 1'b0;
        gdis = 3'b010;
        tick("R8 disable");
        gen = 3'b011;
        tick("R8 group off");
        wwr = 1'b1; wsl = 1'b1;
        tick("R7 sleep write");
        wwr = 1'b0;

        // random traffic with narrow priorities to provoke ties
        for (int n = 0; n < 400; n++) begin
            pend = $urandom; en = $urandom | $urandom; act = $urandom & $urandom;
            for (int i = 0; i < N; i++) begin
                prio[i*PW +: PW] = (n % 3 == 0) ? PW'($urandom_range(0, 3)) : PW'($urandom);
                grp[2*i +: 2] = 2'($urandom);
            end
            gen = 3'($urandom); gdis = 3'($urandom);
            wwr = ($urandom_range(0, 7) == 0); wsl = 1'($urandom);
            ssel = 5'($urandom);
            tick("R2 R3 random");
        end
        wwr = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule